// File: doc/BRIEF.md
# Synchronous Serial Master with Selectable Clock Phase

This block drives a three-wire synchronous serial link as the clock master. It produces the serial clock, shifts a frame out on the data output and shifts a frame in from the data input at the same time. A frame is 7 or 8 bits long and goes out least or most significant bit first. The idle level of the clock is selectable. The data phase is also selectable: either the first bit appears when the clock starts, or it appears half a clock period earlier.

Software-facing control arrives as plain configuration inputs. These are a power-of-two prescaler exponent and a 7-bit divide setting, which together set the bit rate, and a mode bit that chooses between single-transfer and continuous operation. A one-entry transmit buffer sits in front of the shift engine. In continuous mode, a word written before the current frame ends follows it with no idle gap. A single interrupt pulse marks either the end of each frame (single-transfer mode) or each time the buffer is emptied (continuous mode).

Received words are held until they are read. The block keeps a sticky overrun flag for a frame that completes while the previous word is still unread.

Top module: `sync_serial_master`

## Requirements
- R1: With `cfg_len7`=1 a frame carries 7 bits: bit 7 of the transmit word is never sent, and bit 7 of `rx_data` reads 0. With `cfg_len7`=0 a frame carries 8 bits.
- R2: With `cfg_lsb_first`=1, bit 0 goes out and comes in first. With `cfg_lsb_first`=0, the top bit of the frame (bit 6 or bit 7) goes first.
- R3: While `busy` is low, `sclk` equals `cfg_clk_inv`: idle low when 0, idle high when 1.
- R4: With `cfg_early`=1, `sdo` shows the first bit as soon as `busy` rises, before the first `sclk` edge. `sdi` is sampled on every edge leaving the idle level, and `sdo` changes on every edge returning to it. With `cfg_early`=0, `sdo` changes on the edges leaving idle and `sdi` is sampled on the edges returning to idle. In both cases `sdo` never changes while `busy` is low.
- R5: Each half clock period lasts H = 2^min(e,11) × (d+1) system clocks, where e is `cfg_pre_exp` and d is `cfg_div`, and d=0 counts as d=1. A single frame of L bits keeps `busy` high for exactly 2·L·H clocks.
- R6: A word can be written to the buffer through `tx_wr` only when `tx_full` is low. A write while the buffer is full is ignored: the buffered word does not change and no extra frame is sent.
- R7: In continuous mode (`cfg_cont`=1), a word buffered before the last half period ends starts at once. `busy` stays high, and k chained frames last k·2·L·H clocks.
- R8: `irq` is a one-clock pulse. In single-transfer mode it fires once per completed frame. In continuous mode it fires once each time the buffer hands a word to the shift engine.
- R9: When a frame completes, `rx_data` takes the received word and `rx_valid` rises. A pulse on `rx_rd` lowers `rx_valid`.
- R10: `ovf` sets when a frame completes while `rx_valid` is high and `rx_rd` is not asserted in that cycle. It stays set until `ovf_clr`. If a set and a clear fall in the same cycle, the set wins.
- R11: After reset, `busy`, `tx_full`, `rx_valid`, `ovf` and `irq` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| cfg_len7 | input | 1 | 1 selects 7-bit frames, 0 selects 8-bit frames |
| cfg_lsb_first | input | 1 | 1 sends least significant bit first |
| cfg_clk_inv | input | 1 | Serial clock idle level |
| cfg_early | input | 1 | 1 drives the first bit half a period before the clock starts |
| cfg_cont | input | 1 | 1 selects continuous mode and the buffer-empty interrupt |
| cfg_pre_exp | input | 4 | Prescaler exponent, values above 11 treated as 11 |
| cfg_div | input | 7 | Divide setting, divisor is value plus one |
| tx_wr | input | 1 | Write strobe for the transmit buffer |
| tx_data | input | 8 | Word to transmit |
| rx_rd | input | 1 | Acknowledges the received word |
| ovf_clr | input | 1 | Clears the overrun flag |
| sdi | input | 1 | Serial data in |
| sclk | output | 1 | Serial clock |
| sdo | output | 1 | Serial data out |
| busy | output | 1 | A frame is in progress |
| tx_full | output | 1 | Transmit buffer holds a word |
| rx_data | output | 8 | Last received word |
| rx_valid | output | 1 | Received word not yet acknowledged |
| irq | output | 1 | Interrupt pulse |
| ovf | output | 1 | Sticky receive overrun flag |

## Verification
The completion of a frame can land in the same clock as a software read of the received word, or in the same clock as an overrun clear. The bench counts half periods from the first busy cycle and places an `rx_rd` pulse, and later an `ovf_clr` pulse, exactly on the completion edge. With the read on that edge, the expected result is a fresh valid word and no overrun. With the clear on that edge while an unread word is pending, the flag must remain set. A second coincidence is the buffer handing over a word on the final half-period edge in continuous mode. That case is judged by the total busy length and the order of the words the echo slave collects.

// File: rtl/ssm_pkg.sv
package ssm_pkg;

    localparam int WORD_W  = 8;
    localparam int EXP_W   = 4;
    localparam int DIV_W   = 7;
    localparam int EXP_MAX = 11;
    localparam int HALF_W  = DIV_W + 1 + EXP_MAX;
    localparam int HCNT_W  = $clog2(2 * WORD_W);
    localparam int POS_W   = $clog2(WORD_W);

    typedef struct packed {
        logic len7;
        logic lsb_first;
        logic clk_inv;
        logic early;
        logic cont;
    } ssm_mode_t;

    typedef enum logic {
        ENG_IDLE,
        ENG_SHIFT
    } ssm_state_t;

    // number of bits in a frame
    function automatic logic [HCNT_W-1:0] frame_bits(input logic len7);
        return len7 ? HCNT_W'(WORD_W - 1) : HCNT_W'(WORD_W);
    endfunction

    // index of the final half period of a frame
    function automatic logic [HCNT_W-1:0] last_half(input logic len7);
        return len7 ? HCNT_W'(2 * WORD_W - 3) : HCNT_W'(2 * WORD_W - 1);
    endfunction

    // word bit carried by the idx-th serial bit
    function automatic logic [POS_W-1:0] bit_pos(input logic [HCNT_W-1:0] idx,
                                                 input logic len7,
                                                 input logic lsb);
        logic [HCNT_W-1:0] p;
        p = lsb ? idx : (frame_bits(len7) - HCNT_W'(1) - idx);
        return p[POS_W-1:0];
    endfunction

    // system clocks per half serial-clock period
    function automatic logic [HALF_W-1:0] half_period(input logic [EXP_W-1:0] e,
                                                      input logic [DIV_W-1:0] d);
        logic [EXP_W-1:0] ee;
        logic [DIV_W:0]   m;
        ee = (e > EXP_W'(EXP_MAX)) ? EXP_W'(EXP_MAX) : e;
        m  = (d == '0) ? (DIV_W+1)'(2) : ({1'b0, d} + (DIV_W+1)'(1));
        return HALF_W'(m) << ee;
    endfunction

endpackage

// File: rtl/ssm_rate_gen.sv
module ssm_rate_gen
    import ssm_pkg::*;
#(
    parameter int CNT_W = HALF_W
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic [CNT_W-1:0] half_cycles,
    output logic             tick
);

    logic [CNT_W-1:0] cnt_q;
    logic             at_end;

    always_comb begin
        at_end = (cnt_q == half_cycles - CNT_W'(1));
        tick   = run && at_end;
    end

    always_ff @(posedge clk) begin
        if (rst || !run) begin
            cnt_q <= '0;
        end else if (at_end) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_q + CNT_W'(1);
        end
    end

endmodule

// File: rtl/ssm_frame_engine.sv
module ssm_frame_engine
    import ssm_pkg::*;
#(
    parameter int DW = WORD_W
) (
    input  logic          clk,
    input  logic          rst,
    input  ssm_mode_t     mode,
    input  logic          tick,
    input  logic          load,
    input  logic [DW-1:0] load_word,
    input  logic          sdi,
    output logic          running,
    output logic          last_tick,
    output logic          sdo,
    output logic          sclk,
    output logic [DW-1:0] done_word
);

    ssm_state_t        state_q;
    ssm_mode_t         mode_q;
    logic [HCNT_W-1:0] h_q;
    logic              p_q;
    logic [DW-1:0]     tx_q;
    logic [DW-1:0]     rx_q;
    logic              sdo_q;

    logic [HCNT_W-1:0] last_idx;
    logic [HCNT_W-1:0] drv_idx;
    logic [HCNT_W-1:0] smp_idx;
    logic              drv_now;
    logic              smp_now;
    logic              shifting;

    always_comb begin
        shifting  = (state_q == ENG_SHIFT);
        last_idx  = last_half(mode_q.len7);
        last_tick = shifting && tick && (h_q == last_idx);
        drv_now   = mode_q.early ? (h_q[0] && (h_q != last_idx)) : !h_q[0];
        smp_now   = mode_q.early ? !h_q[0] : h_q[0];
        drv_idx   = mode_q.early ? ((h_q + HCNT_W'(1)) >> 1) : (h_q >> 1);
        smp_idx   = h_q >> 1;
        done_word = rx_q;
        if (smp_now) begin
            done_word[bit_pos(smp_idx, mode_q.len7, mode_q.lsb_first)] = sdi;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ENG_IDLE;
            mode_q  <= '0;
            h_q     <= '0;
            p_q     <= 1'b0;
            tx_q    <= '0;
            rx_q    <= '0;
            sdo_q   <= 1'b0;
        end else if (load) begin
            state_q <= ENG_SHIFT;
            mode_q  <= mode;
            h_q     <= '0;
            p_q     <= 1'b0;
            tx_q    <= load_word;
            rx_q    <= '0;
            if (mode.early) begin
                sdo_q <= load_word[bit_pos('0, mode.len7, mode.lsb_first)];
            end
        end else if (last_tick) begin
            state_q <= ENG_IDLE;
            h_q     <= '0;
            p_q     <= 1'b0;
        end else if (shifting && tick) begin
            p_q <= ~p_q;
            h_q <= h_q + HCNT_W'(1);
            if (drv_now) begin
                sdo_q <= tx_q[bit_pos(drv_idx, mode_q.len7, mode_q.lsb_first)];
            end
            if (smp_now) begin
                rx_q[bit_pos(smp_idx, mode_q.len7, mode_q.lsb_first)] <= sdi;
            end
        end
    end

    assign running = shifting;
    assign sdo     = sdo_q;
    assign sclk    = p_q ^ mode.clk_inv;

endmodule

// File: rtl/sync_serial_master.sv
module sync_serial_master
    import ssm_pkg::*;
#(
    parameter int DATA_W = WORD_W,
    parameter int PEXP_W = EXP_W,
    parameter int PDIV_W = DIV_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              cfg_len7,
    input  logic              cfg_lsb_first,
    input  logic              cfg_clk_inv,
    input  logic              cfg_early,
    input  logic              cfg_cont,
    input  logic [PEXP_W-1:0] cfg_pre_exp,
    input  logic [PDIV_W-1:0] cfg_div,
    input  logic              tx_wr,
    input  logic [DATA_W-1:0] tx_data,
    input  logic              rx_rd,
    input  logic              ovf_clr,
    input  logic              sdi,
    output logic              sclk,
    output logic              sdo,
    output logic              busy,
    output logic              tx_full,
    output logic [DATA_W-1:0] rx_data,
    output logic              rx_valid,
    output logic              irq,
    output logic              ovf
);

    localparam int CW = PDIV_W + 1 + EXP_MAX;

    ssm_mode_t         mode;
    logic [CW-1:0]     half_cycles;
    logic              tick;
    logic              running;
    logic              last_tick;
    logic              load;
    logic [DATA_W-1:0] done_word;

    logic              buf_full_q;
    logic [DATA_W-1:0] buf_q;
    logic              irq_q;
    logic              rx_valid_q;
    logic [DATA_W-1:0] rx_q;
    logic              ovf_q;
    logic              ovf_set;

    always_comb begin
        mode.len7      = cfg_len7;
        mode.lsb_first = cfg_lsb_first;
        mode.clk_inv   = cfg_clk_inv;
        mode.early     = cfg_early;
        mode.cont      = cfg_cont;
        half_cycles    = CW'(half_period(EXP_W'(cfg_pre_exp), DIV_W'(cfg_div)));
        load           = buf_full_q && (!running || (last_tick && cfg_cont));
        ovf_set        = last_tick && rx_valid_q && !rx_rd;
    end

    ssm_rate_gen #(.CNT_W(CW)) u_rate (
        .clk         (clk),
        .rst         (rst),
        .run         (running),
        .half_cycles (half_cycles),
        .tick        (tick)
    );

    ssm_frame_engine #(.DW(DATA_W)) u_engine (
        .clk       (clk),
        .rst       (rst),
        .mode      (mode),
        .tick      (tick),
        .load      (load),
        .load_word (buf_q),
        .sdi       (sdi),
        .running   (running),
        .last_tick (last_tick),
        .sdo       (sdo),
        .sclk      (sclk),
        .done_word (done_word)
    );

    // transmit buffer: a write while full is dropped
    always_ff @(posedge clk) begin
        if (rst) begin
            buf_full_q <= 1'b0;
            buf_q      <= '0;
        end else if (load) begin
            buf_full_q <= 1'b0;
        end else if (tx_wr && !buf_full_q) begin
            buf_full_q <= 1'b1;
            buf_q      <= tx_data;
        end
    end

    // interrupt source follows the transfer mode
    always_ff @(posedge clk) begin
        if (rst) begin
            irq_q <= 1'b0;
        end else begin
            irq_q <= cfg_cont ? load : last_tick;
        end
    end

    // receive holding register and overrun flag
    always_ff @(posedge clk) begin
        if (rst) begin
            rx_valid_q <= 1'b0;
            rx_q       <= '0;
            ovf_q      <= 1'b0;
        end else begin
            if (last_tick) begin
                rx_q       <= done_word;
                rx_valid_q <= 1'b1;
            end else if (rx_rd) begin
                rx_valid_q <= 1'b0;
            end
            if (ovf_set) begin
                ovf_q <= 1'b1;
            end else if (ovf_clr) begin
                ovf_q <= 1'b0;
            end
        end
    end

    assign busy     = running;
    assign tx_full  = buf_full_q;
    assign rx_data  = rx_q;
    assign rx_valid = rx_valid_q;
    assign irq      = irq_q;
    assign ovf      = ovf_q;

endmodule

// File: rtl/ssm_checker.sv
module ssm_checker (
    input logic clk,
    input logic rst,
    input logic busy,
    input logic sclk,
    input logic sdo,
    input logic cfg_clk_inv,
    input logic tx_full,
    input logic frame_done,
    input logic irq,
    input logic ovf,
    input logic ovf_clr,
    input logic rx_valid,
    input logic rx_rd
);

    // R3
    idle_level_chk: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sclk == cfg_clk_inv));

    // R4
    sdo_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(sdo) |-> busy);

    // R6
    buf_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_full && busy && !frame_done) |=> tx_full);

    // R8
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        irq |=> !irq);

    // R9
    rx_valid_chk: assert property (@(posedge clk) disable iff (rst)
        frame_done |=> rx_valid);

    // R10
    ovf_set_chk: assert property (@(posedge clk) disable iff (rst)
        (frame_done && rx_valid && !rx_rd) |=> ovf);

    // R10
    ovf_sticky_chk: assert property (@(posedge clk) disable iff (rst)
        (ovf && !ovf_clr) |=> ovf);

endmodule

bind sync_serial_master ssm_checker u_chk (
    .clk         (clk),
    .rst         (rst),
    .busy        (busy),
    .sclk        (sclk),
    .sdo         (sdo),
    .cfg_clk_inv (cfg_clk_inv),
    .tx_full     (tx_full),
    .frame_done  (last_tick),
    .irq         (irq),
    .ovf         (ovf),
    .ovf_clr     (ovf_clr),
    .rx_valid    (rx_valid),
    .rx_rd       (rx_rd)
);

// File: tb/sync_serial_master_bench.sv
module sync_serial_master_bench;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       cfg_len7 = 0, cfg_lsb_first = 0, cfg_clk_inv = 0, cfg_early = 0, cfg_cont = 0;
    logic [3:0] cfg_pre_exp = '0;
    logic [6:0] cfg_div = 7'd1;
    logic       tx_wr = 0, rx_rd = 0, ovf_clr = 0, sdi = 0;
    logic [7:0] tx_data = '0;
    logic       sclk, sdo, busy, tx_full, rx_valid, irq, ovf;
    logic [7:0] rx_data;

    int checks = 0;
    int fails  = 0;
    int irq_cnt = 0;

    always #5 clk = ~clk;

    sync_serial_master u_sync_serial_master (
        .clk(clk), .rst(rst), .cfg_len7(cfg_len7), .cfg_lsb_first(cfg_lsb_first),
        .cfg_clk_inv(cfg_clk_inv), .cfg_early(cfg_early), .cfg_cont(cfg_cont),
        .cfg_pre_exp(cfg_pre_exp), .cfg_div(cfg_div), .tx_wr(tx_wr), .tx_data(tx_data),
        .rx_rd(rx_rd), .ovf_clr(ovf_clr), .sdi(sdi), .sclk(sclk), .sdo(sdo),
        .busy(busy), .tx_full(tx_full), .rx_data(rx_data), .rx_valid(rx_valid),
        .irq(irq), .ovf(ovf)
    );

    always @(negedge clk) if (irq) irq_cnt++;

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
        end
    endtask

    function automatic int flen(input bit l7);
        return l7 ? 7 : 8;
    endfunction

    function automatic int bpos(input int idx, input bit l7, input bit lsb);
        return lsb ? idx : (flen(l7) - 1 - idx);
    endfunction

    function automatic int half_len(input int e, input int d);
        int ee = (e > 11) ? 11 : e;
        int m  = (d == 0) ? 2 : d + 1;
        return m << ee;
    endfunction

    // behavioural echo slave
    logic [7:0] s_words [4];
    logic [7:0] s_rcv   [4];
    logic [7:0] s_acc;
    int s_tcnt, s_tfi, s_scnt, s_rfi;
    bit s_en = 0;

    function automatic void slave_shift();
        int L = flen(cfg_len7);
        if (s_tcnt == L) begin
            s_tfi++;
            s_tcnt = 0;
        end
        sdi = s_words[(s_tfi > 3) ? 3 : s_tfi][bpos(s_tcnt, cfg_len7, cfg_lsb_first)];
        s_tcnt++;
    endfunction

    function automatic void slave_sample();
        int L = flen(cfg_len7);
        s_acc[bpos(s_scnt, cfg_len7, cfg_lsb_first)] = sdo;
        s_scnt++;
        if (s_scnt == L) begin
            if (s_rfi < 4) s_rcv[s_rfi] = s_acc;
            s_rfi++;
            s_scnt = 0;
            s_acc  = '0;
        end
    endfunction

    always @(sclk) begin
        if (s_en) begin
            if ((sclk != cfg_clk_inv) == cfg_early) slave_sample();
            else slave_shift();
        end
    end

    task automatic arm(input logic [7:0] w0, input logic [7:0] w1,
                       input logic [7:0] w2, input logic [7:0] w3);
        s_words[0] = w0; s_words[1] = w1; s_words[2] = w2; s_words[3] = w3;
        for (int i = 0; i < 4; i++) s_rcv[i] = '0;
        s_acc = '0; s_scnt = 0; s_rfi = 0; s_tfi = 0;
        if (cfg_early) begin
            sdi = w0[bpos(0, cfg_len7, cfg_lsb_first)];
            s_tcnt = 1;
        end else begin
            s_tcnt = 0;
        end
        s_en = 1;
    endtask

    task automatic set_cfg(input bit l7, input bit lsb, input bit inv, input bit early,
                           input bit cont, input int e, input int d);
        @(negedge clk);
        s_en = 0;
        cfg_len7 = l7; cfg_lsb_first = lsb; cfg_clk_inv = inv; cfg_early = early;
        cfg_cont = cont; cfg_pre_exp = 4'(e); cfg_div = 7'(d);
        @(negedge clk);
    endtask

    task automatic write_word(input logic [7:0] w);
        @(negedge clk);
        tx_wr = 1; tx_data = w;
        @(negedge clk);
        tx_wr = 0;
    endtask

    task automatic do_frame(input logic [7:0] w, input int pulse_at, input bit prd,
                            input bit pclr, output int bcnt, output logic fsdo);
        write_word(w);
        while (!busy) @(negedge clk);
        fsdo = sdo;
        bcnt = 1;
        while (busy) begin
            if (bcnt == pulse_at) begin
                rx_rd = prd; ovf_clr = pclr;
            end
            @(negedge clk);
            rx_rd = 0; ovf_clr = 0;
            if (busy) bcnt++;
        end
    endtask

    task automatic pulse_ack();
        @(negedge clk); rx_rd = 1; ovf_clr = 1;
        @(negedge clk); rx_rd = 0; ovf_clr = 0;
    endtask

    initial begin
        #(200000 * 10);
        checks++; fails++;
        $display("FAIL watchdog: actual %0d expected %0d", 1, 0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        int bc, i0;
        logic fs;
        logic [7:0] w, sw, m;

        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        // R11 reset state
        check(!busy && !tx_full && !rx_valid && !ovf && !irq, "R11", "reset outputs",
              {busy, tx_full, rx_valid, ovf, irq}, 0);
        check(sclk == 1'b0, "R3", "idle sclk after reset", sclk, 0);

        // sweep every frame format, half period 2
        for (int c = 0; c < 16; c++) begin
            set_cfg(c[0], c[1], c[2], c[3], 0, 0, 1);
            w  = 8'h5A + 8'(c * 29);
            sw = 8'hC3 ^ 8'(c * 13);
            m  = c[0] ? 8'h7F : 8'hFF;
            arm(sw, sw, sw, sw);
            check(sclk == c[2], "R3", "idle level before frame", sclk, c[2]);
            i0 = irq_cnt;
            do_frame(w, 0, 0, 0, bc, fs);
            check(bc == 2 * flen(c[0]) * 2, "R5", "busy length", bc, 2 * flen(c[0]) * 2);
            check((s_rcv[0] & m) == (w & m), "R2", "slave got tx word", s_rcv[0] & m, w & m);
            check(rx_data == (sw & m), "R9", "rx_data", rx_data, sw & m);
            check(rx_valid, "R9", "rx_valid after frame", rx_valid, 1);
            if (c[0]) check(rx_data[7] == 1'b0, "R1", "7-bit rx bit 7", rx_data[7], 0);
            check(sclk == c[2], "R3", "idle level after frame", sclk, c[2]);
            if (c[3]) check(fs == w[bpos(0, c[0], c[1])], "R4", "early first bit", fs,
                            w[bpos(0, c[0], c[1])]);
            @(negedge clk);
            check(irq_cnt - i0 == 1, "R8", "single-mode irq count", irq_cnt - i0, 1);
            pulse_ack();
            check(!rx_valid, "R9", "rx_valid after read", rx_valid, 0);
        end

        // bit rate settings
        for (int k = 0; k < 5; k++) begin
            int e, d;
            e = (k == 0) ? 0 : (k == 1) ? 0 : (k == 2) ? 2 : (k == 3) ? 3 : 13;
            d = (k == 0) ? 0 : (k == 1) ? 3 : (k == 2) ? 2 : (k == 3) ? 1 : 0;
            set_cfg(0, 0, 0, 0, 0, e, d);
            arm(8'h3C, 8'h3C, 8'h3C, 8'h3C);
            do_frame(8'h96, 0, 0, 0, bc, fs);
            check(bc == 16 * half_len(e, d), "R5", "busy length for divider", bc,
                  16 * half_len(e, d));
            check(s_rcv[0] == 8'h96, "R5", "data at divider", s_rcv[0], 8'h96);
            pulse_ack();
        end

        // continuous chaining of three words
        set_cfg(0, 0, 1, 1, 1, 0, 1);
        arm(8'h11, 8'hE2, 8'h4D, 8'h00);
        i0 = irq_cnt;
        bc = 0;
        fork
            begin
                write_word(8'hA1);
                while (tx_full) @(negedge clk);
                write_word(8'h7E);
                while (tx_full) @(negedge clk);
                write_word(8'h39);
            end
            begin
                while (!busy) @(negedge clk);
                while (busy) begin bc++; @(negedge clk); end
            end
        join
        check(bc == 3 * 16 * 2, "R7", "chained busy length", bc, 96);
        check(s_rcv[0] == 8'hA1 && s_rcv[1] == 8'h7E && s_rcv[2] == 8'h39, "R7",
              "chained words in order", s_rcv[2], 8'h39);
        check(irq_cnt - i0 == 3, "R8", "buffer-empty irq count", irq_cnt - i0, 3);
        check(rx_data == 8'h4D, "R9", "last chained rx", rx_data, 8'h4D);
        pulse_ack();

        // write while full is dropped
        set_cfg(0, 1, 0, 0, 0, 0, 1);
        arm(8'h21, 8'h84, 8'h00, 8'h00);
        write_word(8'hB7);
        while (tx_full) @(negedge clk);
        write_word(8'h5C);
        check(tx_full, "R6", "buffer full", tx_full, 1);
        write_word(8'hFF);
        check(tx_full, "R6", "buffer still full", tx_full, 1);
        repeat (150) @(negedge clk);
        check(s_rfi == 2, "R6", "frames sent", s_rfi, 2);
        check(s_rcv[1] == 8'h5C, "R6", "second word kept", s_rcv[1], 8'h5C);
        check(!tx_full, "R6", "buffer drained", tx_full, 0);
        pulse_ack();

        // overrun behaviour
        set_cfg(0, 0, 0, 0, 0, 0, 1);
        arm(8'h0F, 8'hF0, 8'h66, 8'h99);
        pulse_ack();
        do_frame(8'h12, 0, 0, 0, bc, fs);
        check(!ovf && rx_valid, "R10", "no overrun on first word", ovf, 0);
        do_frame(8'h34, 0, 0, 0, bc, fs);
        check(ovf, "R10", "overrun on unread word", ovf, 1);
        check(rx_data == 8'hF0, "R10", "newest word kept", rx_data, 8'hF0);
        @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
        check(!ovf, "R10", "overrun cleared", ovf, 0);
        do_frame(8'h56, 32, 1, 0, bc, fs);
        check(!ovf && rx_valid, "R10", "read on completion edge", ovf, 0);
        check(rx_data == 8'h66, "R9", "rx after coincident read", rx_data, 8'h66);
        do_frame(8'h78, 32, 0, 1, bc, fs);
        check(ovf, "R10", "set wins over clear", ovf, 1);
        @(negedge clk); ovf_clr = 1; @(negedge clk); ovf_clr = 0;
        check(!ovf, "R10", "final clear", ovf, 0);

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule